// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Run-Time Pin Routing

This block pairs an asynchronous serial transmitter with a receiver and configures both through one 8-bit control register. The register picks the character length (8 or 9 data bits), turns hardware parity on or off, chooses even or odd parity, and sets where the idle-line count begins. Its two routing bits connect the receiver to one of three sources: the separate receive pin, the transmitter's own output inside the block, or the shared transmit pin in single-wire half-duplex operation.

Parity does not add a bit to the frame. When parity is on, it takes the place of the top bit of the character. A fixed clock divider produces a tick at 16 times the bit rate. The receiver runs from this tick. The transmitter times each bit as 16 tick periods counted from the moment it accepts a character. Received characters are held in an output register with a valid flag and a parity-error flag. Both flags clear when software acknowledges the character with a read strobe. An idle flag reports one full character time of quiet line after traffic.

Top module: `sci_xcvr`

## Requirements
- R1: After reset the control register reads 0x00, `txd_o` is 1, `txd_oe` is 1, and `tx_busy`, `rx_valid`, `rx_perr` and `idle_flag` are all 0.
- R2: The control bit positions are: bit 7 loop enable, bit 5 receive-source select, bit 4 nine-bit mode, bit 2 idle-count start, bit 1 parity enable, bit 0 odd parity. A write takes effect on the next clock. Bits 6 and 3 always read 0.
- R3: A write of `tx_data` while `tx_busy` is 0 starts a frame on the next clock. The frame is a low start bit, then 8 data bits (9 when nine-bit mode is set) LSB first, then a high stop bit. Each bit lasts 16*CLK_DIV clocks. `tx_busy` stays high for the whole frame. A write while busy is ignored. `txd_o` is 1 whenever the transmitter is not busy.
- R4: With parity enabled, the top character bit is sent as parity in place of data. This is bit 7 in 8-bit mode and bit 8 in 9-bit mode. With the odd bit 0 the count of ones over the character is even. With the odd bit 1 that count is odd.
- R5: With loop enable 0, a frame on `rxd_i` is delivered on `rx_data` with `rx_valid` set. In 8-bit mode `rx_data[8]` is 0. `rx_read` clears `rx_valid`.
- R6: With parity enabled, `rx_perr` is set along with `rx_valid` when the received parity does not match the selected type, and is 0 when it does. `rx_read` clears it.
- R7: With loop enable 1 and receive-source 0, the receiver takes the transmitter output internally and ignores `rxd_i`.
- R8: With loop enable 1 and receive-source 1, the receiver reads the shared pin `txd_i`. `txd_oe` is 1 only while a frame is being sent. A remote frame arriving on the released pin is received.
- R9: With loop enable 0, the receive-source bit has no effect: `txd_oe` stays 1 and reception comes from `rxd_i`.
- R10: A low pulse shorter than half a bit time does not start a character.
- R11: `idle_flag` is set after a full character time (10 bit times in 8-bit mode, 11 in 9-bit mode) of continuous high level that follows a received character. With the idle-start bit 0, counting begins right after the start bit, so trailing data ones and the stop bit count. With it set to 1, counting begins only after the stop bit.
- R12: `idle_flag` is set at most once per idle period. `rx_read` clears it, and it is not set again until another character has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register contents |
| tx_we | input | 1 | Transmit character write strobe |
| tx_data | input | 9 | Character to send (bit 8 used in 9-bit mode) |
| tx_busy | output | 1 | Frame in progress on the transmitter |
| rx_data | output | 9 | Last received character |
| rx_valid | output | 1 | Received character waiting |
| rx_perr | output | 1 | Parity mismatch on the waiting character |
| idle_flag | output | 1 | Idle line seen after traffic |
| rx_read | input | 1 | Acknowledge strobe, clears receive flags |
| rxd_i | input | 1 | Receive pin |
| txd_i | input | 1 | Read-back of the transmit pin |
| txd_o | output | 1 | Transmit pin value |
| txd_oe | output | 1 | Transmit pin drive enable |

## Verification
The hardest timing to reach from the ports is the idle-count start point. With either setting, the flag only fires after a full character time of quiet line, so the two settings differ only in when the flag rises relative to the received character. The bench sends an all-ones character under each setting and times the gap from the end of the frame to the flag. It expects roughly one bit time when the data ones count toward idle and roughly ten when they do not. Single-wire mode is reached by resolving the pin in the bench from `txd_oe`. A remote sender can then drive the released pin, and the block's own frames come back through `txd_i`.

// File: rtl/sci_pkg.sv
// Shared constants and helpers for the serial transceiver.
// Assumes a 9-bit character container; bit 8 is used only in 9-bit mode.
package sci_pkg;
    localparam int CTL_LOOP  = 7;
    localparam int CTL_SRC   = 5;
    localparam int CTL_NINE  = 4;
    localparam int CTL_ILT   = 2;
    localparam int CTL_PEN   = 1;
    localparam int CTL_PODD  = 0;
    localparam logic [7:0] CTL_MASK = 8'hB7;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_t;

    // Build the character to send, replacing the top bit with parity when enabled.
    function automatic logic [8:0] apply_parity(input logic [8:0] d, input logic nine,
                                                input logic pen, input logic podd);
        logic [8:0] c;
        c = nine ? d : {1'b0, d[7:0]};
        if (pen) begin
            if (nine) c[8] = (^c[7:0]) ^ podd;
            else      c[7] = (^c[6:0]) ^ podd;
        end
        return c;
    endfunction

    // True when a received character fails the selected parity type.
    function automatic logic parity_bad(input logic [8:0] c, input logic nine,
                                        input logic podd);
        return (nine ? (^c[8:0]) : (^c[7:0])) ^ podd;
    endfunction
endpackage

// File: rtl/sci_tick_gen.sv
// Free-running divider that emits a one-clock tick every DIV clocks.
// Assumes DIV >= 2.
module sci_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = $clog2(DIV);
    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == W'(DIV - 1));

    // Count clocks and wrap at the divide value.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sci_tx.sv
// Frame transmitter: start, 8 or 9 character bits LSB first, stop.
// Bit timing is counted from the accepting clock; format is latched at start.
module sci_tx
    import sci_pkg::*;
#(
    parameter int BIT_CLKS = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [8:0] data,
    input  logic       nine,
    input  logic       pen,
    input  logic       podd,
    output logic       busy,
    output logic       line
);
    localparam int CW = $clog2(BIT_CLKS);

    logic          busy_q;
    logic [10:0]   sh_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    idx_q;
    logic [3:0]    last_q;
    logic [8:0]    chr;
    logic [10:0]   frame_d;

    // Assemble the outgoing frame from the character and current format.
    always_comb begin
        chr     = apply_parity(data, nine, pen, podd);
        frame_d = nine ? {1'b1, chr, 1'b0} : {2'b11, chr[7:0], 1'b0};
    end

    // Accept a character when free, then step through bits on bit-time boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sh_q   <= '1;
            cnt_q  <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                sh_q   <= frame_d;
                cnt_q  <= '0;
                idx_q  <= '0;
                last_q <= nine ? 4'd10 : 4'd9;
            end
        end else if (cnt_q == CW'(BIT_CLKS - 1)) begin
            cnt_q <= '0;
            if (idx_q == last_q) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                sh_q  <= {1'b1, sh_q[10:1]};
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy = busy_q;
    assign line = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sci_rx.sv
// Oversampling receiver with parity check and idle-line detection.
// Assumes a synchronised input line and a tick at OVS times the bit rate.
module sci_rx
    import sci_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       nine,
    input  logic       pen,
    input  logic       podd,
    input  logic       ilt,
    input  logic       rd,
    output logic [8:0] data,
    output logic       valid,
    output logic       perr,
    output logic       idle
);
    localparam int TW = $clog2(OVS);
    localparam int IW = $clog2(11 * OVS + 1);
    localparam logic [TW-1:0] MID = TW'(OVS / 2 + 1);
    localparam logic [TW-1:0] S0  = TW'(OVS / 2 - 1);
    localparam logic [TW-1:0] S1  = TW'(OVS / 2);

    rx_state_t     state_q;
    logic [TW-1:0] tcnt_q;
    logic [3:0]    bidx_q;
    logic [8:0]    shb_q;
    logic [1:0]    samp_q;
    logic          vote;
    logic          done;
    logic [8:0]    chr;
    logic [IW-1:0] icnt_q;
    logic [IW-1:0] thr;
    logic          armed_q;

    assign vote = (samp_q[0] & samp_q[1]) | (samp_q[0] & line) | (samp_q[1] & line);
    assign done = tick && (state_q == RX_DATA) && (tcnt_q == MID) &&
                  (bidx_q == (nine ? 4'd9 : 4'd8));
    assign chr  = nine ? shb_q : {1'b0, shb_q[8:1]};
    assign thr  = nine ? IW'(11 * OVS) : IW'(10 * OVS);

    // Frame sequencer: start qualification, majority sampling, bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            shb_q   <= '0;
            samp_q  <= 2'b11;
        end else if (tick) begin
            if (state_q == RX_IDLE) begin
                if (!line) begin
                    state_q <= RX_START;
                    tcnt_q  <= '0;
                end
            end else begin
                tcnt_q <= (tcnt_q == TW'(OVS - 1)) ? '0 : tcnt_q + 1'b1;
                if (tcnt_q == S0) samp_q[0] <= line;
                if (tcnt_q == S1) samp_q[1] <= line;
                if (tcnt_q == MID) begin
                    if (state_q == RX_START) begin
                        state_q <= vote ? RX_IDLE : RX_DATA;
                        bidx_q  <= '0;
                    end else if (done) begin
                        state_q <= RX_IDLE;
                    end else begin
                        shb_q  <= {vote, shb_q[8:1]};
                        bidx_q <= bidx_q + 1'b1;
                    end
                end
            end
        end
    end

    // Hold the received character and its flags until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
            perr  <= 1'b0;
        end else if (done) begin
            data  <= chr;
            valid <= 1'b1;
            perr  <= pen & parity_bad(chr, nine, podd);
        end else if (rd) begin
            valid <= 1'b0;
            perr  <= 1'b0;
        end
    end

    // Count high ticks from the selected start point and raise idle once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt_q  <= '0;
            armed_q <= 1'b0;
            idle    <= 1'b0;
        end else begin
            if (tick) begin
                if (!line || (ilt && state_q != RX_IDLE)) icnt_q <= '0;
                else if (icnt_q < thr)                    icnt_q <= icnt_q + 1'b1;
            end
            if (done) begin
                armed_q <= 1'b1;
            end else if (armed_q && icnt_q >= thr) begin
                armed_q <= 1'b0;
                idle    <= 1'b1;
            end else if (rd) begin
                idle    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sci_xcvr.sv
// Top of the serial transceiver: control register, receive-source routing,
// input synchroniser and the tick divider. Assumes the pin pad returns the
// resolved transmit-pin level on txd_i.
module sci_xcvr
    import sci_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int OVS     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tx_we,
    input  logic [8:0] tx_data,
    output logic       tx_busy,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    output logic       idle_flag,
    input  logic       rx_read,
    input  logic       rxd_i,
    input  logic       txd_i,
    output logic       txd_o,
    output logic       txd_oe
);
    localparam int BIT_CLKS = CLK_DIV * OVS;

    logic [7:0] ctl_q;
    logic [1:0] sync_q;
    logic       tick;
    logic       tx_line;
    logic       rx_src;
    logic       single;

    // Control register with reserved bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (reg_we) ctl_q <= reg_wdata & CTL_MASK;
    end

    assign single = ctl_q[CTL_LOOP] & ctl_q[CTL_SRC];
    assign rx_src = !ctl_q[CTL_LOOP] ? rxd_i : (ctl_q[CTL_SRC] ? txd_i : tx_line);

    // Two-stage synchroniser on the selected receive source.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_src};
    end

    sci_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    sci_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_we), .data(tx_data),
        .nine(ctl_q[CTL_NINE]), .pen(ctl_q[CTL_PEN]), .podd(ctl_q[CTL_PODD]),
        .busy(tx_busy), .line(tx_line)
    );

    sci_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(sync_q[1]),
        .nine(ctl_q[CTL_NINE]), .pen(ctl_q[CTL_PEN]), .podd(ctl_q[CTL_PODD]),
        .ilt(ctl_q[CTL_ILT]), .rd(rx_read),
        .data(rx_data), .valid(rx_valid), .perr(rx_perr), .idle(idle_flag)
    );

    assign reg_rdata = ctl_q;
    assign txd_o     = tx_line;
    assign txd_oe    = !single | tx_busy;
endmodule

// File: rtl/sci_xcvr_chk.sv
// Port-level properties of the transceiver, attached by bind.
module sci_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       tx_busy,
    input logic       rx_valid,
    input logic       rx_perr,
    input logic       rx_read,
    input logic       txd_o,
    input logic       txd_oe
);
    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_rdata == ($past(reg_wdata) & 8'hB7));
    // R3
    tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd_o);
    // R3
    tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd_o);
    // R8
    pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] && reg_rdata[5] && !tx_busy) |-> !txd_oe);
    // R5
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_valid) |-> $past(rx_read));
    // R6
    perr_with_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_perr) |-> rx_valid);
endmodule

bind sci_xcvr sci_xcvr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_busy(tx_busy), .rx_valid(rx_valid),
    .rx_perr(rx_perr), .rx_read(rx_read), .txd_o(txd_o), .txd_oe(txd_oe)
);

// File: tb/test_sci_xcvr.sv
module test_sci_xcvr;
    localparam int DIV = 4;
    localparam int BP  = DIV * 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_we = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_busy;
    logic [8:0] rx_data;
    logic       rx_valid, rx_perr, idle_flag;
    logic       rx_read = 1'b0;
    logic       rline = 1'b1;
    logic       remote = 1'b1;
    logic       txd_o, txd_oe;
    logic       txd_pin;

    int compared = 0;
    int mismatched = 0;

    // bench-side state
    logic [7:0]  bctl = '0;
    bit          mbusy = 0;
    int          mpos = 0;
    int          mnb = 10;
    logic [10:0] mframe = '1;
    string       mreq = "R3";

    assign txd_pin = txd_oe ? txd_o : remote;

    always #4 clk = ~clk;

    sci_xcvr #(.CLK_DIV(DIV)) i_sci_xcvr (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_we(tx_we), .tx_data(tx_data), .tx_busy(tx_busy),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
        .idle_flag(idle_flag), .rx_read(rx_read), .rxd_i(rline), .txd_i(txd_pin),
        .txd_o(txd_o), .txd_oe(txd_oe)
    );

    function automatic logic [10:0] build(input logic [8:0] d, input bit nine,
                                          input bit pen, input bit podd);
        logic [8:0] c;
        c = nine ? d : {1'b0, d[7:0]};
        if (pen) begin
            if (nine) c[8] = (^c[7:0]) ^ podd;
            else      c[7] = (^c[6:0]) ^ podd;
        end
        return nine ? {1'b1, c, 1'b0} : {2'b11, c[7:0], 1'b0};
    endfunction

    function automatic logic [8:0] char_of(input logic [10:0] fr, input bit nine);
        return nine ? fr[9:1] : {1'b0, fr[8:1]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // transmitter reference: frame position advanced on every clock
    always @(posedge clk) begin
        bit was;
        if (!rst_n) begin
            mbusy = 0;
            mpos  = 0;
        end else begin
            was = mbusy;
            if (was) begin
                mpos++;
                if (mpos == mnb * BP) mbusy = 0;
            end
            if (!was && tx_we) begin
                mbusy  = 1;
                mpos   = 0;
                mnb    = bctl[4] ? 11 : 10;
                mframe = build(tx_data, bctl[4], bctl[1], bctl[0]);
                mreq   = bctl[1] ? "R4" : "R3";
            end
        end
    end

    // compare the pin outputs against the reference on every clock
    always @(negedge clk) begin
        logic exp_txd, exp_oe;
        if (rst_n) begin
            exp_txd = mbusy ? mframe[mpos / BP] : 1'b1;
            exp_oe  = (bctl[7] && bctl[5]) ? mbusy : 1'b1;
            check(txd_o === exp_txd, mreq, "txd_o", int'(txd_o), int'(exp_txd));
            check(tx_busy === mbusy, "R3", "tx_busy", int'(tx_busy), int'(mbusy));
            check(txd_oe === exp_oe, bctl[7] ? "R8" : "R9", "txd_oe",
                  int'(txd_oe), int'(exp_oe));
        end
    end

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(posedge clk);
        bctl = v & 8'hB7;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic send_tx(input logic [8:0] d);
        @(negedge clk);
        tx_we = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic wait_tx();
        do @(negedge clk); while (mbusy);
        repeat (8) @(negedge clk);
    endtask

    task automatic drive(input bit to_remote, input logic [10:0] fr, input int nb);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            if (to_remote) remote = fr[i];
            else           rline = fr[i];
            repeat (BP - 1) @(negedge clk);
        end
    endtask

    task automatic ack();
        @(negedge clk);
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic chk_rx(input logic [8:0] exp, input bit exp_perr, input string req);
        repeat (4) @(negedge clk);
        check(rx_valid === 1'b1, req, "rx_valid", int'(rx_valid), 1);
        check(rx_data === exp, req, "rx_data", int'(rx_data), int'(exp));
        check(rx_perr === exp_perr, req, "rx_perr", int'(rx_perr), int'(exp_perr));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        logic [10:0] fr;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check(reg_rdata === 8'h00, "R1", "reg_rdata", int'(reg_rdata), 0);
        check(txd_o === 1'b1 && txd_oe === 1'b1, "R1", "txd pins",
              int'({txd_o, txd_oe}), 3);
        check({tx_busy, rx_valid, rx_perr, idle_flag} === 4'b0, "R1", "flags",
              int'({tx_busy, rx_valid, rx_perr, idle_flag}), 0);

        // R2 reserved bits read zero
        wr_ctl(8'hFF);
        check(reg_rdata === 8'hB7, "R2", "reg_rdata", int'(reg_rdata), 'hB7);
        wr_ctl(8'h00);
        check(reg_rdata === 8'h00, "R2", "reg_rdata", int'(reg_rdata), 0);

        // R3 8-bit frame, plus a write while busy that must be ignored
        send_tx(9'h05A);
        repeat (3 * BP) @(negedge clk);
        send_tx(9'h1FF);
        wait_tx();
        // R3 9-bit frame
        wr_ctl(8'h10);
        send_tx(9'h1A5);
        wait_tx();
        // R4 even parity 8-bit, odd parity 9-bit
        wr_ctl(8'h02);
        send_tx(9'h007);
        wait_tx();
        wr_ctl(8'h13);
        send_tx(9'h0F3);
        wait_tx();

        // R5 normal reception
        wr_ctl(8'h00);
        fr = build(9'h0C3, 0, 0, 0);
        drive(0, fr, 10);
        chk_rx(9'h0C3, 0, "R5");
        ack();
        check(rx_valid === 1'b0, "R5", "rx_valid after read", int'(rx_valid), 0);

        // R6 parity check, good then bad
        wr_ctl(8'h02);
        fr = build(9'h035, 0, 1, 0);
        drive(0, fr, 10);
        chk_rx(char_of(fr, 0), 0, "R6");
        ack();
        fr[8] = ~fr[8];
        drive(0, fr, 10);
        chk_rx(char_of(fr, 0), 1, "R6");
        ack();
        check(rx_perr === 1'b0, "R6", "rx_perr after read", int'(rx_perr), 0);
        wr_ctl(8'h13);
        fr = build(9'h0F3, 1, 1, 1);
        drive(0, fr, 11);
        chk_rx(char_of(fr, 1), 0, "R6");
        ack();

        // R7 internal loopback ignores rxd_i
        wr_ctl(8'h80);
        rline = 1'b0;
        repeat (12 * BP) @(negedge clk);
        check(rx_valid === 1'b0, "R7", "rx_valid with rxd low", int'(rx_valid), 0);
        send_tx(9'h03C);
        wait_tx();
        chk_rx(9'h03C, 0, "R7");
        ack();
        rline = 1'b1;

        // R8 single-wire: own frame and a remote frame on the shared pin
        wr_ctl(8'hA0);
        send_tx(9'h096);
        wait_tx();
        chk_rx(9'h096, 0, "R8");
        ack();
        rline = 1'b0;
        fr = build(9'h04B, 0, 0, 0);
        drive(1, fr, 10);
        chk_rx(9'h04B, 0, "R8");
        ack();
        rline = 1'b1;

        // R9 source bit without loop enable
        wr_ctl(8'h20);
        fr = build(9'h066, 0, 0, 0);
        drive(0, fr, 10);
        chk_rx(9'h066, 0, "R9");
        ack();

        // R10 short low pulse rejected
        wr_ctl(8'h00);
        repeat (12 * BP) @(negedge clk);
        ack();
        rline = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rline = 1'b1;
        repeat (12 * BP) @(negedge clk);
        check(rx_valid === 1'b0, "R10", "rx_valid after glitch", int'(rx_valid), 0);

        // R11 idle start after start bit
        fr = build(9'h0FF, 0, 0, 0);
        drive(0, fr, 10);
        n = 0;
        while (!idle_flag && n < 20 * BP) begin @(negedge clk); n++; end
        check(n >= BP / 2 && n < 2 * BP, "R11", "idle delay ILT=0", n, BP);
        ack();
        // R11 idle start after stop bit
        wr_ctl(8'h04);
        drive(0, fr, 10);
        n = 0;
        while (!idle_flag && n < 20 * BP) begin @(negedge clk); n++; end
        check(n > 8 * BP && n < 11 * BP, "R11", "idle delay ILT=1", n, 10 * BP);
        ack();
        // R12 not raised again without a new character
        repeat (25 * BP) @(negedge clk);
        check(idle_flag === 1'b0, "R12", "idle_flag re-raise", int'(idle_flag), 0);
        drive(0, fr, 10);
        repeat (12 * BP) @(negedge clk);
        check(idle_flag === 1'b1, "R12", "idle_flag after new char", int'(idle_flag), 1);

        summary();
    end
endmodule